// File: doc/BRIEF.md
# PODEM Test Pattern Search Engine

This block searches for a test stimulus for one single stuck-at fault in a small combinational netlist that is built into it. A caller gives a line index, a stuck value and a backtrack budget, then pulses `start`. The engine makes decisions only on the four primary inputs, in a fixed order. After each decision it evaluates the whole netlist in a five-valued calculus (0, 1, X, D, D'), with the fault injected at the chosen line. A depth-first decision stack lets it return to earlier choices. The search ends with one of three outcomes: a test was found, the fault is untestable (redundant), or the search was aborted because the budget was used up.

The built-in netlist uses line indices 0..10. Lines 0..3 are the primary inputs a, b, c and d. The gates are: line 4 = NOT a, line 5 = a AND b, line 6 = line4 AND c, line 7 = b AND c, line 8 = line5 OR line6, line 9 = line8 OR line7 (output y0), and line 10 = line4 AND d (output y1). Line 7 is the consensus term of y0, so its stuck-at-0 fault is redundant.

The controller has five states. IDLE waits for `start`. IMPLY looks at the evaluated netlist. DECIDE assigns the next input. BACKTRACK undoes or flips decisions. REPORT raises `done` for one cycle. The transitions are:
- IDLE to IMPLY on an accepted start.
- IMPLY to REPORT when a test is found.
- IMPLY to BACKTRACK when the search cannot succeed.
- IMPLY to DECIDE otherwise.
- DECIDE to IMPLY after the decision.
- BACKTRACK to itself when it pops a decision.
- BACKTRACK to IMPLY when it flips a decision.
- BACKTRACK to REPORT on untestable or abort.
- REPORT to IDLE.

Top module: `podem_engine`

## Requirements
- R1: After reset, busy, done, found, untestable and aborted are 0, and bt_count is 0.
- R2: A start seen while the engine is idle (busy=0 and done=0) makes busy 1 in the next cycle. The engine latches fault_line, fault_sa and bt_limit at that point. A start seen while busy or done is 1 has no effect on the running search or on its result.
- R3: Lines are evaluated in five-valued logic. D means good 1 / faulty 0, and D' means good 0 / faulty 1. AND with a 0 gives 0, and AND of 1 with v gives v. OR with a 1 gives 1, and OR of 0 with v gives v. AND of D with D' gives 0, and OR of D with D' gives 1. NOT swaps D and D'. Every other mix that involves X gives X. Any vector reported as found, with its don't-care inputs set either way, makes y0 or y1 differ between the good and the faulty netlist.
- R4: The search starts with every input at X. Each decision assigns 0 to the lowest-indexed unassigned input. A flipped decision takes the value 1.
- R5: The fault line carries D when its good value is 1 and the fault is stuck-at-0. It carries D' when its good value is 0 and the fault is stuck-at-1. It carries the stuck value when the good value equals it, and X while the good value is X. This holds for input lines as well as gate lines.
- R6: A test is found as soon as y0 or y1 carries D or D'. Then found=1, test_care bit i is 1 exactly when input i (a=bit0 … d=bit3) is assigned, and test_vec bit i holds that input's value (0 where it is not cared).
- R7: The current assignment counts as hopeless, and a backtrack follows, in three cases: the fault line holds a binary value; the fault line holds D or D' but no gate has a D/D' input together with an X output; or no input is left unassigned.
- R8: A backtrack removes, newest first, every decision whose alternate value has already been tried. It then flips the newest untried decision to 1. bt_count counts the flips.
- R9: When a backtrack finds the decision stack empty, the outcome is untestable=1.
- R10: When a flip is needed and bt_count already equals the latched bt_limit, the outcome is aborted=1 and bt_count stays at the limit. A limit of 0 aborts at the first flip.
- R11: busy stays 1 from the cycle after the accepted start until the result. done is then 1 for exactly one cycle, with busy=0 and exactly one of found, untestable or aborted set. Those three flags are 0 whenever done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search when idle |
| fault_line | input | 4 | Index of the faulty line, 0..10 |
| fault_sa | input | 1 | Stuck value of the fault |
| bt_limit | input | 8 | Maximum number of decision flips |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| found | output | 1 | A test was found (with done) |
| untestable | output | 1 | Fault proven redundant (with done) |
| aborted | output | 1 | Backtrack budget exhausted (with done) |
| test_vec | output | 4 | Assigned input values of the test |
| test_care | output | 4 | Mask of assigned inputs of the test |
| bt_count | output | 8 | Number of decision flips made |

## Verification
The assertions take for granted that fault_line names an existing line (0..10) whenever a start is accepted. They also assume the inputs matter only in that cycle, because the engine latches the fault and the limit itself. The abort check compares bt_count against the limit the checker latched at the accepted start, so it holds no matter how bt_limit moves afterwards. The stimulus only uses line indices 0..10 and drives every input at the falling clock edge. It raises start once while a search runs, and that start carries a different fault and limit, so an accidental restart would change the reported outcome.

// File: rtl/podem_pkg.sv
package podem_pkg;

    localparam int NUM_PI    = 4;
    localparam int NUM_GATES = 7;
    localparam int NUM_LINES = NUM_PI + NUM_GATES;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int PI_IDX_W  = $clog2(NUM_PI);
    localparam int PO_LINE0  = 9;
    localparam int PO_LINE1  = 10;

    typedef enum logic [2:0] {
        V0  = 3'd0,
        V1  = 3'd1,
        VX  = 3'd2,
        VD  = 3'd3,
        VDB = 3'd4
    } val5_t;

    typedef enum logic [1:0] {
        G_AND = 2'd0,
        G_OR  = 2'd1,
        G_NOT = 2'd2
    } gate_kind_e;

    typedef struct packed {
        logic known;
        logic bit_v;
    } rail_t;

    // Gate g drives line NUM_PI + g
    function automatic gate_kind_e gate_kind(int g);
        case (g)
            0:       return G_NOT;
            4, 5:    return G_OR;
            default: return G_AND;
        endcase
    endfunction

    function automatic int gate_a(int g);
        case (g)
            0, 1:    return 0;
            2:       return 4;
            3:       return 1;
            4:       return 5;
            5:       return 8;
            default: return 4;
        endcase
    endfunction

    function automatic int gate_b(int g);
        case (g)
            0:       return 0;
            1:       return 1;
            2, 3:    return 2;
            4:       return 6;
            5:       return 7;
            default: return 3;
        endcase
    endfunction

    function automatic logic line_is_po(int l);
        return (l == PO_LINE0) || (l == PO_LINE1);
    endfunction

    function automatic rail_t rail_good(val5_t v);
        case (v)
            V0, VDB: return '{known: 1'b1, bit_v: 1'b0};
            V1, VD:  return '{known: 1'b1, bit_v: 1'b1};
            default: return '{known: 1'b0, bit_v: 1'b0};
        endcase
    endfunction

    function automatic rail_t rail_bad(val5_t v);
        case (v)
            V0, VD:  return '{known: 1'b1, bit_v: 1'b0};
            V1, VDB: return '{known: 1'b1, bit_v: 1'b1};
            default: return '{known: 1'b0, bit_v: 1'b0};
        endcase
    endfunction

    function automatic rail_t rail_and(rail_t a, rail_t b);
        if ((a.known && !a.bit_v) || (b.known && !b.bit_v))
            return '{known: 1'b1, bit_v: 1'b0};
        if (a.known && b.known)
            return '{known: 1'b1, bit_v: 1'b1};
        return '{known: 1'b0, bit_v: 1'b0};
    endfunction

    function automatic rail_t rail_or(rail_t a, rail_t b);
        if ((a.known && a.bit_v) || (b.known && b.bit_v))
            return '{known: 1'b1, bit_v: 1'b1};
        if (a.known && b.known)
            return '{known: 1'b1, bit_v: 1'b0};
        return '{known: 1'b0, bit_v: 1'b0};
    endfunction

    function automatic val5_t rail_join(rail_t g, rail_t f);
        if (!g.known || !f.known)
            return VX;
        case ({g.bit_v, f.bit_v})
            2'b00:   return V0;
            2'b11:   return V1;
            2'b10:   return VD;
            default: return VDB;
        endcase
    endfunction

    function automatic val5_t and5(val5_t a, val5_t b);
        return rail_join(rail_and(rail_good(a), rail_good(b)),
                         rail_and(rail_bad(a),  rail_bad(b)));
    endfunction

    function automatic val5_t or5(val5_t a, val5_t b);
        return rail_join(rail_or(rail_good(a), rail_good(b)),
                         rail_or(rail_bad(a),  rail_bad(b)));
    endfunction

    function automatic val5_t not5(val5_t a);
        case (a)
            V0:      return V1;
            V1:      return V0;
            VD:      return VDB;
            VDB:     return VD;
            default: return VX;
        endcase
    endfunction

    function automatic logic is_err(val5_t v);
        return (v == VD) || (v == VDB);
    endfunction

    // Replace the value on the faulty line by its good/faulty pair
    function automatic val5_t inject(val5_t v, logic sa);
        rail_t g;
        g = rail_good(v);
        if (!g.known)
            return VX;
        if (g.bit_v == sa)
            return sa ? V1 : V0;
        return sa ? VDB : VD;
    endfunction

endpackage

// File: rtl/podem_pick.sv
module podem_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  known,
    output logic [IW-1:0] idx,
    output logic          any_free
);

    always_comb begin
        idx      = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!known[i]) begin
                idx      = IW'(i);
                any_free = 1'b1;
            end
        end
    end

endmodule

// File: rtl/podem_stack.sv
module podem_stack #(
    parameter int DEPTH = 4,
    parameter int IW    = 2,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          flip,
    input  logic          pop,
    output logic [IW-1:0] top_idx,
    output logic          top_tried,
    output logic          empty
);

    logic [DW-1:0]             depth_q;
    logic [DEPTH-1:0][IW-1:0]  ent_idx;
    logic [DEPTH-1:0]          ent_tried;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            depth_q <= '0;
        else if (clear)
            depth_q <= '0;
        else if (push)
            depth_q <= depth_q + DW'(1);
        else if (pop)
            depth_q <= depth_q - DW'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [IW-1:0] idx_r;
        logic          tried_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_r   <= '0;
                tried_r <= 1'b0;
            end else if (clear) begin
                tried_r <= 1'b0;
            end else if (push && depth_q == DW'(g)) begin
                idx_r   <= push_idx;
                tried_r <= 1'b0;
            end else if (flip && depth_q == DW'(g + 1)) begin
                tried_r <= 1'b1;
            end
        end

        assign ent_idx[g]   = idx_r;
        assign ent_tried[g] = tried_r;
    end

    always_comb begin
        top_idx   = '0;
        top_tried = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (depth_q == DW'(i + 1)) begin
                top_idx   = ent_idx[i];
                top_tried = ent_tried[i];
            end
        end
    end

    assign empty = (depth_q == '0);

endmodule

// File: rtl/podem_eval.sv
module podem_eval
    import podem_pkg::*;
(
    input  logic [NUM_PI-1:0] asg_known,
    input  logic [NUM_PI-1:0] asg_val,
    input  logic [LINE_W-1:0] fault_line,
    input  logic              fault_sa,
    output logic              out_err,
    output logic              site_lost,
    output logic              site_err,
    output logic              frontier_any
);

    always_comb begin
        val5_t v [NUM_LINES];
        val5_t raw;
        val5_t site;
        int    ga;
        int    gb;

        site         = VX;
        out_err      = 1'b0;
        frontier_any = 1'b0;

        for (int l = 0; l < NUM_LINES; l++) begin
            if (l < NUM_PI) begin
                raw = asg_known[l] ? (asg_val[l] ? V1 : V0) : VX;
            end else begin
                ga = gate_a(l - NUM_PI);
                gb = gate_b(l - NUM_PI);
                unique case (gate_kind(l - NUM_PI))
                    G_AND:   raw = and5(v[ga], v[gb]);
                    G_OR:    raw = or5(v[ga], v[gb]);
                    G_NOT:   raw = not5(v[ga]);
                    default: raw = VX;
                endcase
            end
            if (fault_line == LINE_W'(l)) begin
                v[l] = inject(raw, fault_sa);
                site = v[l];
            end else begin
                v[l] = raw;
            end
        end

        for (int l = 0; l < NUM_LINES; l++) begin
            if (line_is_po(l) && is_err(v[l]))
                out_err = 1'b1;
        end

        for (int g = 0; g < NUM_GATES; g++) begin
            if (v[NUM_PI + g] == VX &&
                (is_err(v[gate_a(g)]) || is_err(v[gate_b(g)])))
                frontier_any = 1'b1;
        end

        site_err  = is_err(site);
        site_lost = (site == V0) || (site == V1);
    end

endmodule

// File: rtl/podem_engine.sv
module podem_engine
    import podem_pkg::*;
#(
    parameter int BT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LINE_W-1:0] fault_line,
    input  logic              fault_sa,
    input  logic [BT_W-1:0]   bt_limit,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic              untestable,
    output logic              aborted,
    output logic [NUM_PI-1:0] test_vec,
    output logic [NUM_PI-1:0] test_care,
    output logic [BT_W-1:0]   bt_count
);

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_IMPLY     = 3'd1,
        ST_DECIDE    = 3'd2,
        ST_BACKTRACK = 3'd3,
        ST_REPORT    = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_FOUND = 2'd1,
        RES_REDUN = 2'd2,
        RES_ABORT = 2'd3
    } result_e;

    state_e              state_q, state_d;
    result_e             result_q, result_d;
    logic [LINE_W-1:0]   line_q;
    logic                sa_q;
    logic [BT_W-1:0]     limit_q;
    logic [BT_W-1:0]     bt_q;
    logic [NUM_PI-1:0]   known_q;
    logic [NUM_PI-1:0]   val_q;

    logic                do_init, do_push, do_flip, do_pop, do_result;

    logic                out_err, site_lost, site_err, frontier_any;
    logic [PI_IDX_W-1:0] pick_idx;
    logic                any_free;
    logic [PI_IDX_W-1:0] top_idx;
    logic                top_tried, stk_empty;
    logic                hopeless;

    podem_eval eval_i (
        .asg_known    (known_q),
        .asg_val      (val_q),
        .fault_line   (line_q),
        .fault_sa     (sa_q),
        .out_err      (out_err),
        .site_lost    (site_lost),
        .site_err     (site_err),
        .frontier_any (frontier_any)
    );

    podem_pick #(.N(NUM_PI), .IW(PI_IDX_W)) pick_i (
        .known    (known_q),
        .idx      (pick_idx),
        .any_free (any_free)
    );

    podem_stack #(.DEPTH(NUM_PI), .IW(PI_IDX_W)) stack_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_init),
        .push      (do_push),
        .push_idx  (pick_idx),
        .flip      (do_flip),
        .pop       (do_pop),
        .top_idx   (top_idx),
        .top_tried (top_tried),
        .empty     (stk_empty)
    );

    assign hopeless = site_lost || !any_free || (site_err && !frontier_any);

    // Next state and control strobes
    always_comb begin
        state_d   = state_q;
        result_d  = result_q;
        do_init   = 1'b0;
        do_push   = 1'b0;
        do_flip   = 1'b0;
        do_pop    = 1'b0;
        do_result = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    do_init = 1'b1;
                    state_d = ST_IMPLY;
                end
            end
            ST_IMPLY: begin
                if (out_err) begin
                    do_result = 1'b1;
                    result_d  = RES_FOUND;
                    state_d   = ST_REPORT;
                end else if (hopeless) begin
                    state_d = ST_BACKTRACK;
                end else begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                do_push = 1'b1;
                state_d = ST_IMPLY;
            end
            ST_BACKTRACK: begin
                if (stk_empty) begin
                    do_result = 1'b1;
                    result_d  = RES_REDUN;
                    state_d   = ST_REPORT;
                end else if (top_tried) begin
                    do_pop = 1'b1;
                end else if (bt_q == limit_q) begin
                    do_result = 1'b1;
                    result_d  = RES_ABORT;
                    state_d   = ST_REPORT;
                end else begin
                    do_flip = 1'b1;
                    state_d = ST_IMPLY;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= RES_NONE;
            line_q   <= '0;
            sa_q     <= 1'b0;
            limit_q  <= '0;
            bt_q     <= '0;
            known_q  <= '0;
            val_q    <= '0;
        end else begin
            if (do_init) begin
                result_q <= RES_NONE;
                line_q   <= fault_line;
                sa_q     <= fault_sa;
                limit_q  <= bt_limit;
                bt_q     <= '0;
                known_q  <= '0;
                val_q    <= '0;
            end
            if (do_push) begin
                known_q[pick_idx] <= 1'b1;
                val_q[pick_idx]   <= 1'b0;
            end
            if (do_flip) begin
                val_q[top_idx] <= 1'b1;
                bt_q           <= bt_q + BT_W'(1);
            end
            if (do_pop) begin
                known_q[top_idx] <= 1'b0;
                val_q[top_idx]   <= 1'b0;
            end
            if (do_result)
                result_q <= result_d;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q == ST_IMPLY) || (state_q == ST_DECIDE) ||
                     (state_q == ST_BACKTRACK);
        done       = (state_q == ST_REPORT);
        found      = done && (result_q == RES_FOUND);
        untestable = done && (result_q == RES_REDUN);
        aborted    = done && (result_q == RES_ABORT);
        test_care  = found ? known_q : '0;
        test_vec   = found ? (val_q & known_q) : '0;
        bt_count   = bt_q;
    end

endmodule

// File: rtl/podem_engine_chk.sv
module podem_engine_chk
    import podem_pkg::*;
#(
    parameter int BT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LINE_W-1:0] fault_line,
    input logic [BT_W-1:0]   bt_limit,
    input logic              busy,
    input logic              done,
    input logic              found,
    input logic              untestable,
    input logic              aborted,
    input logic [NUM_PI-1:0] test_vec,
    input logic [NUM_PI-1:0] test_care,
    input logic [BT_W-1:0]   bt_count
);

    logic [BT_W-1:0] lim_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lim_seen <= '0;
        else if (start && !busy && !done)
            lim_seen <= bt_limit;
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);

    assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |-> (fault_line < LINE_W'(NUM_LINES)));

    assert_found_care_R6: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((test_care != '0) && ((test_vec & ~test_care) == '0)));

    assert_bt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((bt_count == $past(bt_count)) ||
                                   (bt_count == $past(bt_count) + BT_W'(1))));

    assert_abort_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> (bt_count == lim_seen));

    assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bt_count <= lim_seen));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({found, untestable, aborted}));

    assert_flags_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(found || untestable || aborted));

    assert_busy_until_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

endmodule

bind podem_engine podem_engine_chk #(.BT_W(BT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fault_line (fault_line),
    .bt_limit   (bt_limit),
    .busy       (busy),
    .done       (done),
    .found      (found),
    .untestable (untestable),
    .aborted    (aborted),
    .test_vec   (test_vec),
    .test_care  (test_care),
    .bt_count   (bt_count)
);

// File: tb/podem_engine_tb.sv
module podem_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] fault_line = '0;
    logic       fault_sa = 1'b0;
    logic [7:0] bt_limit = '0;
    logic       busy, done, found, untestable, aborted;
    logic [3:0] test_vec, test_care;
    logic [7:0] bt_count;

    int errors = 0;
    int checks = 0;

    // captured result of the last run
    logic       r_found, r_redun, r_abort;
    logic [3:0] r_vec, r_care;
    logic [7:0] r_bt;

    always #2.5 clk = ~clk;

    podem_engine dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fault_line (fault_line),
        .fault_sa   (fault_sa),
        .bt_limit   (bt_limit),
        .busy       (busy),
        .done       (done),
        .found      (found),
        .untestable (untestable),
        .aborted    (aborted),
        .test_vec   (test_vec),
        .test_care  (test_care),
        .bt_count   (bt_count)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bench model of the netlist in two-valued logic, fault forced on line fl
    function automatic logic [1:0] net2(logic [3:0] x, int fl, logic sa, logic inj);
        logic [10:0] n;
        for (int k = 0; k < 4; k++) n[k] = (inj && fl == k) ? sa : x[k];
        n[4]  = (inj && fl == 4)  ? sa : ~n[0];
        n[5]  = (inj && fl == 5)  ? sa : (n[0] & n[1]);
        n[6]  = (inj && fl == 6)  ? sa : (n[4] & n[2]);
        n[7]  = (inj && fl == 7)  ? sa : (n[1] & n[2]);
        n[8]  = (inj && fl == 8)  ? sa : (n[5] | n[6]);
        n[9]  = (inj && fl == 9)  ? sa : (n[8] | n[7]);
        n[10] = (inj && fl == 10) ? sa : (n[4] & n[3]);
        return {n[10], n[9]};
    endfunction

    task automatic launch(input int line, input logic sa, input logic [7:0] lim);
        @(negedge clk);
        fault_line = 4'(line);
        fault_sa   = sa;
        bt_limit   = lim;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", "busy after start", 32'(busy), 32'd1);
    endtask

    task automatic await_done();
        while (!done) @(negedge clk);
        r_found = found;
        r_redun = untestable;
        r_abort = aborted;
        r_vec   = test_vec;
        r_care  = test_care;
        r_bt    = bt_count;
        check("R11", "busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        check("R11", "done lasts one cycle", 32'(done), 32'd0);
    endtask

    task automatic run(input int line, input logic sa, input logic [7:0] lim);
        launch(line, sa, lim);
        await_done();
    endtask

    task automatic check_detects(input int line, input logic sa);
        logic ok = 1'b1;
        for (int m = 0; m < 16; m++) begin
            if ((4'(m) & r_care) == (r_vec & r_care)) begin
                if (net2(4'(m), line, sa, 1'b0) == net2(4'(m), line, sa, 1'b1))
                    ok = 1'b0;
            end
        end
        check("R3", "vector detects fault for every fill", 32'(ok), 32'd1);
    endtask

    task automatic expect_found(input string req, input logic [3:0] vec,
                                input logic [3:0] care, input logic [7:0] bt);
        check(req, "found", 32'(r_found), 32'd1);
        check(req, "test_vec", 32'(r_vec), 32'(vec));
        check(req, "test_care", 32'(r_care), 32'(care));
        check(req, "bt_count", 32'(r_bt), 32'(bt));
    endtask

    task automatic t_reset();
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "flags", 32'({found, untestable, aborted}), 32'd0);
        check("R1", "bt_count", 32'(bt_count), 32'd0);
    endtask

    task automatic t_and_gate_sa0();
        // R4 R8: a=0 loses site, flip; b=0 loses site, flip; c=0 reaches y0
        run(5, 1'b0, 8'd15);
        expect_found("R4", 4'b0011, 4'b0111, 8'd2);
        check_detects(5, 1'b0);
    endtask

    task automatic t_consensus_sa1();
        // R5: D' on line 7 with a=b=0, c=0 clears the other y0 terms
        run(7, 1'b1, 8'd15);
        expect_found("R5", 4'b0000, 4'b0111, 8'd0);
        check_detects(7, 1'b1);
    endtask

    task automatic t_input_faults();
        // R5: fault on input d provoked only when d is decided
        run(3, 1'b1, 8'd15);
        expect_found("R5", 4'b0000, 4'b1111, 8'd0);
        check_detects(3, 1'b1);
        // R3 R7: a sa0, D' through NOT, frontier dies at d=0, d flipped
        run(0, 1'b0, 8'd15);
        expect_found("R7", 4'b1001, 4'b1111, 8'd2);
        check_detects(0, 1'b0);
    endtask

    task automatic t_output_fault();
        // R6 R7: output line y1 sa0 lost at d=0, flip d gives D at output
        run(10, 1'b0, 8'd15);
        expect_found("R6", 4'b1000, 4'b1111, 8'd1);
        check_detects(10, 1'b0);
    endtask

    task automatic t_redundant();
        run(7, 1'b0, 8'd15);
        check("R9", "untestable", 32'(r_redun), 32'd1);
        check("R9", "found", 32'(r_found), 32'd0);
        check("R9", "care zero", 32'(r_care), 32'd0);
        check("R8", "flip count", 32'(r_bt), 32'd5);
    endtask

    task automatic t_abort_limits();
        run(7, 1'b0, 8'd4);
        check("R10", "aborted at limit 4", 32'(r_abort), 32'd1);
        check("R10", "bt_count at limit 4", 32'(r_bt), 32'd4);
        run(7, 1'b0, 8'd5);
        check("R10", "limit 5 still untestable", 32'(r_redun), 32'd1);
        check("R10", "bt_count limit 5", 32'(r_bt), 32'd5);
        run(7, 1'b0, 8'd0);
        check("R10", "aborted at limit 0", 32'(r_abort), 32'd1);
        check("R10", "bt_count limit 0", 32'(r_bt), 32'd0);
    endtask

    task automatic t_start_while_busy();
        launch(7, 1'b0, 8'd15);
        @(negedge clk);
        @(negedge clk);
        check("R2", "still busy", 32'(busy), 32'd1);
        fault_line = 4'd5;
        fault_sa   = 1'b0;
        bt_limit   = 8'd0;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        await_done();
        check("R2", "ignored start keeps outcome", 32'(r_redun), 32'd1);
        check("R2", "ignored start keeps count", 32'(r_bt), 32'd5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_and_gate_sa0();
        t_consensus_sa1();
        t_input_faults();
        t_output_fault();
        t_redundant();
        t_abort_limits();
        t_start_while_busy();
        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule